// File: doc/BRIEF.md
# Link Low-Power Substate Controller

This block sequences the clock and power controls that a serial link keeps on its physical-layer side. It moves the link between the fully active state, a shallow low-power state, two deeper substates and an off state. Protocol logic asks for entry with a one-cycle request and a requested depth. Two configuration bits decide whether each deeper substate may be used. A wake pulse brings the link back.

Each depth turns off one more group of resources, one per cycle, in a fixed order. The shallow state only stops the reference clock, so the PLL keeps running. Leaving a low-power state turns the resources back on in the opposite order. The PLL must report lock before the transmitter/receiver is re-enabled. A down-counter then runs for an exit latency that grows with how deep the link went. The controller reports readiness only when that counter has finished.

Coming back from the off state also raises a retrain request. The two per-direction bridge clock enables are passed through while the link is active and held low otherwise.

Top module: `linkPmSeq`

## Requirements
- R1: After reset the link is active: `linkReady`=1, `refClkEn`, `phyEn`, `pllEn` and `cmKeepEn` are all 1, and `retrainReq`=0.
- R2: While `linkReady`=1, `masterClkEn` equals `mstDirEn` and `slaveClkEn` equals `slvDirEn`. While `linkReady`=0, both are 0.
- R3: Target code 0 (shallow state) turns off only `refClkEn`; `pllEn`, `phyEn` and `cmKeepEn` stay 1.
- R4: Entry drops `linkReady` on the edge that samples `entryReq`. On each following edge it turns off one resource in the order reference clock, transmitter/receiver, PLL, common-mode keeper. Target code 1 turns off the first three; codes 2 and 3 turn off all four.
- R5: Exit turns the resources back on one per edge in the reverse order: keeper, PLL, transmitter/receiver, reference clock. The first step happens on the edge after the one that samples `wakeEvt`.
- R6: `phyEn` is not turned back on while `pllLock`=0.
- R7: Let n be the number of resources off and L the exit latency. `linkReady` rises n+1+L edges after the edge that samples `wakeEvt`, if lock is immediate. L is `baseLatency` times 1 (only the reference clock off), times MULT_L11 (PLL off but keeper on) or times MULT_L12 (keeper off).
- R8: Target code 2 with `deepL12En`=0 falls back to code 1 if `deepL11En`=1, or to code 0 otherwise. Target code 1 with `deepL11En`=0 falls back to code 0.
- R9: A wake sampled during entry stops the shutdown. Exit then runs only over the resources already off.
- R10: After the off state (code 3) has been fully reached, `retrainReq` is a one-cycle pulse in the first cycle `linkReady` is 1. Other exits, including an aborted entry to the off state, give no pulse.
- R11: `entryReq` is ignored unless the link is active. `wakeEvt` is ignored while the link is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| entryReq | input | 1 | One-cycle request to enter low power |
| targetSub | input | 2 | Requested depth: 0 shallow, 1 deep, 2 deepest, 3 off |
| deepL11En | input | 1 | Allows depth 1 |
| deepL12En | input | 1 | Allows depth 2 |
| wakeEvt | input | 1 | Wake pulse |
| pllLock | input | 1 | PLL lock indication |
| baseLatency | input | LAT_W | Baseline exit latency in cycles |
| mstDirEn | input | 1 | Inbound bridge clock request |
| slvDirEn | input | 1 | Outbound bridge clock request |
| refClkEn | output | 1 | Reference clock enable |
| pllEn | output | 1 | PLL enable |
| phyEn | output | 1 | Transmitter/receiver enable |
| cmKeepEn | output | 1 | Common-mode keeper enable |
| retrainReq | output | 1 | Retrain request pulse |
| linkReady | output | 1 | Link active and ready |
| masterClkEn | output | 1 | Gated inbound bridge clock enable |
| slaveClkEn | output | 1 | Gated outbound bridge clock enable |

## Verification
All outputs are registered. A resource enable changes on the edge after the decision, and readiness changes on the edge that leaves the latency wait. The bench drives inputs on falling edges, samples on falling edges and counts falling edges from the wake. The expected count is n+2+L, one more than the edge count in R7 because counting starts before the sampling edge.

A scoreboard checks ordering without relying on absolute timing. The scenario driver queues each enable, ready or retrain transition it expects. A monitor pops one entry per observed change, so a step out of order, an extra step or a missing step fails. Exact latency, held states, fallback depths and the lock stall are checked at fixed falling edges.

// File: rtl/linkPmPkg.sv
package linkPmPkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_ENTER,
    ST_LOW,
    ST_EXIT,
    ST_SETTLE
  } pmState_t;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic capture;   // latch the effective depth
    logic offStep;   // switch off the next resource
    logic onStep;    // switch the last-off resource back on
    logic loadCnt;   // load exit latency counter
    logic decCnt;    // count latency down
    logic goActive;  // returning to active
  } pmStrobe_t;

  localparam int NUM_RES = 4; // 0 ref clock, 1 tx/rx, 2 PLL, 3 keeper

  localparam logic [1:0] DEPTH_SHALLOW = 2'd0;
  localparam logic [1:0] DEPTH_DEEP    = 2'd1;
  localparam logic [1:0] DEPTH_DEEPEST = 2'd2;
  localparam logic [1:0] DEPTH_OFF     = 2'd3;

endpackage

// File: rtl/linkPmPath.sv
module linkPmPath
  import linkPmPkg::*;
#(
  parameter int LAT_W    = 16,
  parameter int MULT_L11 = 5,
  parameter int MULT_L12 = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  pmStrobe_t           stb,
  input  logic [1:0]          targetSub,
  input  logic                deepL11En,
  input  logic                deepL12En,
  input  logic [LAT_W-1:0]    baseLatency,
  output logic [2:0]          offCount,
  output logic [2:0]          stagesNeeded,
  output logic                cntZero,
  output logic [NUM_RES-1:0]  resEn,
  output logic                retrainReq
);

  localparam int CNT_W = LAT_W + $clog2(MULT_L12 + 1);

  logic [1:0]       effDepth;
  logic [1:0]       depthQ;
  logic [2:0]       offNext;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] latVal;
  logic             fromOffQ;

  // Fall back to a shallower depth when a deep one is not allowed
  always_comb begin
    effDepth = targetSub;
    if (targetSub == DEPTH_DEEPEST && !deepL12En)
      effDepth = deepL11En ? DEPTH_DEEP : DEPTH_SHALLOW;
    else if (targetSub == DEPTH_DEEP && !deepL11En)
      effDepth = DEPTH_SHALLOW;
  end

  always_comb begin
    case (depthQ)
      DEPTH_SHALLOW: stagesNeeded = 3'd1;
      DEPTH_DEEP:    stagesNeeded = 3'd3;
      default:       stagesNeeded = 3'd4;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            depthQ <= DEPTH_SHALLOW;
    else if (stb.capture) depthQ <= effDepth;
  end

  always_comb begin
    offNext = offCount;
    if (stb.offStep)     offNext = offCount + 3'd1;
    else if (stb.onStep) offNext = offCount - 3'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) offCount <= 3'd0;
    else       offCount <= offNext;
  end

  // Resource k is off while more than k resources are off
  for (genvar k = 0; k < NUM_RES; k++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resEn[k] <= 1'b1;
      else       resEn[k] <= (offNext <= 3'(k));
    end
  end

  // Latency class chosen by the deepest resource that is off
  always_comb begin
    case (offCount)
      3'd0, 3'd1: latVal = CNT_W'(baseLatency);
      3'd2, 3'd3: latVal = CNT_W'(baseLatency) * CNT_W'(MULT_L11);
      default:    latVal = CNT_W'(baseLatency) * CNT_W'(MULT_L12);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.loadCnt) cntQ <= latVal;
    else if (stb.decCnt)  cntQ <= cntQ - CNT_W'(1);
  end

  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fromOffQ   <= 1'b0;
      retrainReq <= 1'b0;
    end else begin
      retrainReq <= stb.goActive & fromOffQ;
      if (stb.goActive)
        fromOffQ <= 1'b0;
      else if (stb.offStep && depthQ == DEPTH_OFF && offNext == 3'd4)
        fromOffQ <= 1'b1;
    end
  end

endmodule

// File: rtl/linkPmCtrl.sv
module linkPmCtrl
  import linkPmPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      entryReq,
  input  logic      wakeEvt,
  input  logic      pllLock,
  input  logic [2:0] offCount,
  input  logic [2:0] stagesNeeded,
  input  logic      cntZero,
  output pmStrobe_t stb,
  output logic      linkReady
);

  pmState_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_ACTIVE: begin
        if (entryReq) begin
          stb.capture = 1'b1;
          nextState   = ST_ENTER;
        end
      end
      ST_ENTER: begin
        if (wakeEvt) begin
          stb.loadCnt = 1'b1;
          nextState   = ST_EXIT;
        end else begin
          stb.offStep = 1'b1;
          if (offCount + 3'd1 == stagesNeeded) nextState = ST_LOW;
        end
      end
      ST_LOW: begin
        if (wakeEvt) begin
          stb.loadCnt = 1'b1;
          nextState   = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (offCount == 3'd0) begin
          nextState = ST_SETTLE;
        end else if (offCount != 3'd2 || pllLock) begin
          // stepping from 2 to 1 re-enables tx/rx: needs PLL lock
          stb.onStep = 1'b1;
          if (offCount == 3'd1) nextState = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (cntZero) begin
          stb.goActive = 1'b1;
          nextState    = ST_ACTIVE;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ACTIVE;
      linkReady <= 1'b1;
    end else begin
      state     <= nextState;
      linkReady <= (nextState == ST_ACTIVE);
    end
  end

endmodule

// File: rtl/linkPmSeq.sv
module linkPmSeq
  import linkPmPkg::*;
#(
  parameter int LAT_W    = 16,
  parameter int MULT_L11 = 5,
  parameter int MULT_L12 = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             entryReq,
  input  logic [1:0]       targetSub,
  input  logic             deepL11En,
  input  logic             deepL12En,
  input  logic             wakeEvt,
  input  logic             pllLock,
  input  logic [LAT_W-1:0] baseLatency,
  input  logic             mstDirEn,
  input  logic             slvDirEn,
  output logic             refClkEn,
  output logic             pllEn,
  output logic             phyEn,
  output logic             cmKeepEn,
  output logic             retrainReq,
  output logic             linkReady,
  output logic             masterClkEn,
  output logic             slaveClkEn
);

  pmStrobe_t          stb;
  logic [2:0]         offCount;
  logic [2:0]         stagesNeeded;
  logic               cntZero;
  logic [NUM_RES-1:0] resEn;

  linkPmCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .entryReq     (entryReq),
    .wakeEvt      (wakeEvt),
    .pllLock      (pllLock),
    .offCount     (offCount),
    .stagesNeeded (stagesNeeded),
    .cntZero      (cntZero),
    .stb          (stb),
    .linkReady    (linkReady)
  );

  linkPmPath #(
    .LAT_W    (LAT_W),
    .MULT_L11 (MULT_L11),
    .MULT_L12 (MULT_L12)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .targetSub    (targetSub),
    .deepL11En    (deepL11En),
    .deepL12En    (deepL12En),
    .baseLatency  (baseLatency),
    .offCount     (offCount),
    .stagesNeeded (stagesNeeded),
    .cntZero      (cntZero),
    .resEn        (resEn),
    .retrainReq   (retrainReq)
  );

  assign refClkEn    = resEn[0];
  assign phyEn       = resEn[1];
  assign pllEn       = resEn[2];
  assign cmKeepEn    = resEn[3];
  assign masterClkEn = linkReady & mstDirEn;
  assign slaveClkEn  = linkReady & slvDirEn;

endmodule

// File: rtl/linkPmSeqChk.sv
module linkPmSeqChk (
  input logic clk,
  input logic rstN,
  input logic pllLock,
  input logic refClkEn,
  input logic pllEn,
  input logic phyEn,
  input logic cmKeepEn,
  input logic retrainReq,
  input logic linkReady,
  input logic masterClkEn,
  input logic slaveClkEn
);

  p_gate_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    !linkReady |-> (!masterClkEn && !slaveClkEn));

  p_shut_pll_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllEn) |-> (!phyEn && !refClkEn));

  p_shut_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmKeepEn) |-> !pllEn);

  p_restore_pll_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllEn) |-> cmKeepEn);

  p_restore_ref_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refClkEn) |-> (phyEn && pllEn && cmKeepEn));

  p_lock_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyEn) |-> $past(pllLock));

  p_ready_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    linkReady |-> (refClkEn && phyEn && pllEn && cmKeepEn));

  p_retrain_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    retrainReq |-> linkReady);

  p_retrain_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    retrainReq |=> !retrainReq);

endmodule

bind linkPmSeq linkPmSeqChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pllLock     (pllLock),
  .refClkEn    (refClkEn),
  .pllEn       (pllEn),
  .phyEn       (phyEn),
  .cmKeepEn    (cmKeepEn),
  .retrainReq  (retrainReq),
  .linkReady   (linkReady),
  .masterClkEn (masterClkEn),
  .slaveClkEn  (slaveClkEn)
);

// File: tb/linkPmSeq_test.sv
module linkPmSeq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        entryReq = 1'b0;
  logic [1:0]  targetSub = 2'd0;
  logic        deepL11En = 1'b1;
  logic        deepL12En = 1'b1;
  logic        wakeEvt = 1'b0;
  logic        lockGate = 1'b1;
  logic        pllLock;
  logic [15:0] baseLatency = 16'(LAT);
  logic        mstDirEn = 1'b0;
  logic        slvDirEn = 1'b0;
  logic        refClkEn, pllEn, phyEn, cmKeepEn, retrainReq, linkReady;
  logic        masterClkEn, slaveClkEn;

  int checks = 0;
  int fails  = 0;
  logic monOn = 1'b0;
  logic [5:0] prevBits;
  byte evQ[$];

  assign pllLock = pllEn & lockGate;

  always #(CLK_PERIOD/2) clk = ~clk;

  linkPmSeq uut (
    .clk(clk), .rstN(rstN), .entryReq(entryReq), .targetSub(targetSub),
    .deepL11En(deepL11En), .deepL12En(deepL12En), .wakeEvt(wakeEvt),
    .pllLock(pllLock), .baseLatency(baseLatency), .mstDirEn(mstDirEn),
    .slvDirEn(slvDirEn), .refClkEn(refClkEn), .pllEn(pllEn), .phyEn(phyEn),
    .cmKeepEn(cmKeepEn), .retrainReq(retrainReq), .linkReady(linkReady),
    .masterClkEn(masterClkEn), .slaveClkEn(slaveClkEn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Event code: bit index*2 + new value; bits ref,phy,pll,keep,ready,retrain
  task automatic pushEntry(input int n);
    evQ.push_back(8'd8);
    for (int k = 0; k < n; k++) evQ.push_back(8'(2*k));
  endtask

  task automatic pushExit(input int n);
    for (int k = n-1; k >= 0; k--) evQ.push_back(8'(2*k+1));
    evQ.push_back(8'd9);
  endtask

  task automatic pulseEntry(input logic [1:0] tgt);
    @(negedge clk); entryReq = 1'b1; targetSub = tgt;
    @(negedge clk); entryReq = 1'b0;
  endtask

  // Caller raises wakeEvt at a falling edge; counts falling edges to ready
  task automatic waitReady(output int cnt, output logic rt);
    @(negedge clk); wakeEvt = 1'b0; cnt = 1;
    while (!linkReady && cnt < 2000) begin
      @(negedge clk); cnt++;
    end
    rt = retrainReq;
  endtask

  task automatic wakeTimed(input int expCnt, input string tag, output logic rt);
    int cnt;
    @(negedge clk); wakeEvt = 1'b1;
    waitReady(cnt, rt);
    check(cnt == expCnt, tag, cnt, expCnt);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (monOn) begin
      automatic logic [5:0] cur = {retrainReq, linkReady, cmKeepEn, pllEn, phyEn, refClkEn};
      for (int i = 0; i < 6; i++) begin
        if (cur[i] != prevBits[i]) begin
          automatic byte code = 8'(2*i + int'(cur[i]));
          if (evQ.size() == 0) begin
            check(1'b0, "R4/R5 unexpected transition", int'(code), -1);
          end else begin
            automatic byte expc = evQ.pop_front();
            check(code == expc, "R4/R5 transition order", int'(code), int'(expc));
          end
        end
      end
      prevBits = cur;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic rt;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(linkReady == 1'b1, "R1 ready", int'(linkReady), 1);
    check({cmKeepEn, pllEn, phyEn, refClkEn} == 4'hF, "R1 enables",
          int'({cmKeepEn, pllEn, phyEn, refClkEn}), 15);
    check(retrainReq == 1'b0, "R1 retrain", int'(retrainReq), 0);
    prevBits = {retrainReq, linkReady, cmKeepEn, pllEn, phyEn, refClkEn};
    monOn = 1'b1;

    // R2 pass-through while active
    mstDirEn = 1'b1; slvDirEn = 1'b0;
    @(negedge clk);
    check(masterClkEn == 1'b1 && slaveClkEn == 1'b0, "R2 inbound only",
          int'({masterClkEn, slaveClkEn}), 2);
    mstDirEn = 1'b0; slvDirEn = 1'b1;
    @(negedge clk);
    check(masterClkEn == 1'b0 && slaveClkEn == 1'b1, "R2 outbound only",
          int'({masterClkEn, slaveClkEn}), 1);

    // R11 wake while active has no effect
    wakeEvt = 1'b1; @(negedge clk); wakeEvt = 1'b0;
    repeat (3) @(negedge clk);
    check(linkReady == 1'b1, "R11 wake in active", int'(linkReady), 1);
    mstDirEn = 1'b1;

    // R3 shallow state
    pushEntry(1);
    pulseEntry(2'd0);
    repeat (5) @(negedge clk);
    check(refClkEn == 1'b0 && phyEn && pllEn && cmKeepEn, "R3 only refclk off",
          int'({cmKeepEn, pllEn, phyEn, refClkEn}), 14);
    check(masterClkEn == 1'b0 && slaveClkEn == 1'b0, "R2 gated in low power",
          int'({masterClkEn, slaveClkEn}), 0);
    // R11 entry ignored while low
    pulseEntry(2'd2);
    repeat (5) @(negedge clk);
    check(cmKeepEn && pllEn && !refClkEn, "R11 entry ignored in low",
          int'({cmKeepEn, pllEn, phyEn, refClkEn}), 14);
    pushExit(1);
    wakeTimed(1 + 2 + LAT, "R7 shallow exit latency", rt);
    check(rt == 1'b0, "R10 no retrain shallow", int'(rt), 0);

    // R4 deep state (code 1)
    pushEntry(3);
    pulseEntry(2'd1);
    repeat (6) @(negedge clk);
    check({cmKeepEn, pllEn, phyEn, refClkEn} == 4'b1000, "R4 deep resources",
          int'({cmKeepEn, pllEn, phyEn, refClkEn}), 8);
    pushExit(3);
    wakeTimed(3 + 2 + 5*LAT, "R7 deep exit latency", rt);

    // R4 deepest (code 2)
    pushEntry(4);
    pulseEntry(2'd2);
    repeat (7) @(negedge clk);
    check({cmKeepEn, pllEn, phyEn, refClkEn} == 4'b0000, "R4 deepest resources",
          int'({cmKeepEn, pllEn, phyEn, refClkEn}), 0);
    pushExit(4);
    wakeTimed(4 + 2 + 15*LAT, "R7 deepest exit latency", rt);
    check(rt == 1'b0, "R10 no retrain deepest", int'(rt), 0);

    // R8 fallbacks
    deepL12En = 1'b0;
    pushEntry(3);
    pulseEntry(2'd2);
    repeat (6) @(negedge clk);
    check({cmKeepEn, pllEn, phyEn, refClkEn} == 4'b1000, "R8 code2 to code1",
          int'({cmKeepEn, pllEn, phyEn, refClkEn}), 8);
    pushExit(3);
    wakeTimed(3 + 2 + 5*LAT, "R8 fallback latency", rt);
    deepL11En = 1'b0;
    pushEntry(1);
    pulseEntry(2'd1);
    repeat (6) @(negedge clk);
    check({cmKeepEn, pllEn, phyEn, refClkEn} == 4'b1110, "R8 code1 to code0",
          int'({cmKeepEn, pllEn, phyEn, refClkEn}), 14);
    pushExit(1);
    wakeTimed(1 + 2 + LAT, "R8 fallback shallow latency", rt);
    deepL11En = 1'b1; deepL12En = 1'b1;

    // R6 lock stall
    pushEntry(3);
    pulseEntry(2'd1);
    repeat (6) @(negedge clk);
    lockGate = 1'b0;
    pushExit(3);
    @(negedge clk); wakeEvt = 1'b1;
    @(negedge clk); wakeEvt = 1'b0;
    repeat (10) @(negedge clk);
    check(pllEn == 1'b1 && phyEn == 1'b0 && linkReady == 1'b0, "R6 tx/rx held without lock",
          int'({pllEn, phyEn, linkReady}), 4);
    lockGate = 1'b1;
    cnt = 0;
    while (!linkReady && cnt < 500) begin @(negedge clk); cnt++; end
    check(linkReady == 1'b1, "R6 resumes after lock", int'(linkReady), 1);

    // R10 off state and retrain pulse
    pushEntry(4);
    pulseEntry(2'd3);
    repeat (7) @(negedge clk);
    pushExit(4);
    evQ.push_back(8'd11);
    evQ.push_back(8'd10);
    wakeTimed(4 + 2 + 15*LAT, "R7 off exit latency", rt);
    check(rt == 1'b1, "R10 retrain with ready", int'(rt), 1);
    @(negedge clk);
    check(retrainReq == 1'b0, "R10 retrain one cycle", int'(retrainReq), 0);

    // R9 abort during entry (code 2), one resource off
    pushEntry(1);
    pushExit(1);
    @(negedge clk); entryReq = 1'b1; targetSub = 2'd2;
    @(negedge clk); entryReq = 1'b0;
    @(negedge clk); wakeEvt = 1'b1;
    waitReady(cnt, rt);
    check(cnt == 1 + 2 + LAT, "R9 abort exit latency", cnt, 1 + 2 + LAT);

    // R10 aborted off entry gives no retrain
    pushEntry(1);
    pushExit(1);
    @(negedge clk); entryReq = 1'b1; targetSub = 2'd3;
    @(negedge clk); entryReq = 1'b0;
    @(negedge clk); wakeEvt = 1'b1;
    waitReady(cnt, rt);
    check(rt == 1'b0, "R10 aborted off no retrain", int'(rt), 0);

    repeat (3) @(negedge clk);
    check(evQ.size() == 0, "R5 all expected transitions seen", evQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule